// File: doc/BRIEF.md
# Serial configuration stream loader

This block takes a configuration stream one bit per configuration clock. It first looks for a header, which is a 4-bit start code followed by a 24-bit length count. It then loads a fixed number of frames. Each frame is a start bit, a run of data bits and a 4-bit check value. Every frame that passes its check is written to a configuration memory model through a one-cycle parallel write strobe. A frame that fails its check stops loading and raises an open-drain style request that the INIT line be pulled low.

The block also drives a chain output for the next device in a daisy chain. In the normal mode this output repeats the header and holds high while this device takes its own frames, so the next device never sees a frame start. When this device's frames are done, the output repeats the stream again. In the express mode the length is not used. The chain output is then a plain enable that stays low until this device is fully configured and goes high after that.

A data bit at a fixed position early in the first frame selects the eight-times faster configuration clock. This block only reports that selection and does not generate any clock.

Top module: `cfgld_top`

## Requirements
- R1: While reset is active and after reset is released, `chain_out`, `init_low_o`, `cfg_done`, `fast_clk_sel` and `mem_we` are 0.
- R2: A header is recognised when the last four input bits are 0,0,1,0 in order, after idle high bits. The next 24 bits, most significant first, form the length count. In the normal mode `chain_out` equals the input bit of the previous clock through the idle bits and the whole header.
- R3: In the normal mode `chain_out` is 1 from the clock after each frame's start bit is taken until the clock after the last frame's final check bit.
- R4: A frame is a 0 start bit, then FRAME_BITS data bits sent most significant first, then 4 check bits equal to CHK_PATTERN (default 0101, sent most significant first). After the last check bit of a good frame, `mem_we` is 1 for one clock. In that clock `mem_addr` holds the frame index, counting from 0, and `mem_data` holds the data with the first data bit as its most significant bit.
- R5: A check field that differs from the pattern, or a start bit of 1, sets `init_low_o`. After that there are no more writes, `cfg_done` stays 0, in the normal mode `chain_out` stays 1, and `init_low_o` holds until reset.
- R6: In the normal mode, after the last frame, `chain_out` again equals the input bit of the previous clock.
- R7: In the normal mode, clocks are counted from the first start-code bit, which is clock 1. `cfg_done` is 1 from the later of two points: the clock at which the count reaches length+4, and the last frame's final check bit. Both conditions require that no error has occurred, and `cfg_done` holds until reset.
- R8: In the express mode the length value has no effect. `cfg_done` is 1 from the fourth clock after the last frame's final check bit, and `chain_out` equals `cfg_done` at all times.
- R9: `fast_clk_sel` becomes 1 after data bit FAST_POS of frame 0 (default 2, counted from 0 in arrival order) if that bit is 1. Otherwise it stays 0. Once set it holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_din | input | 1 | Serial configuration data |
| express_en | input | 1 | 1 selects the express mode; held static during a load |
| chain_out | output | 1 | Output to the next device in the chain |
| init_low_o | output | 1 | Request to pull INIT low because of a frame error |
| cfg_done | output | 1 | Configuration complete |
| fast_clk_sel | output | 1 | Fast configuration clock requested |
| mem_we | output | 1 | Frame write strobe |
| mem_addr | output | AW | Frame index for the write |
| mem_data | output | FRAME_BITS | Frame data for the write |

## Verification
If the bit or frame position counter slips, the chain output changes state in the wrong clock. It rises one bit early or late at the header boundary, or falls back to pass-through in the wrong place. The bench compares the chain output against the stream on every clock, so such a slip shows within one bit. A wrong count of clocks or tail clocks moves the clock in which `cfg_done` rises, and the bench checks that clock exactly. A frame parsed out of alignment gives a failed check field, so `init_low_o` rises at that frame's last bit, and the bench sees either the error or a wrong write address and data.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int LEN_W  = 24;
    localparam int PRE_W  = 4;
    localparam logic [PRE_W-1:0] PRE_CODE = 4'b0010;
    localparam int CHK_W  = 4;
    localparam int TAIL   = 4;

    typedef enum logic [2:0] {
        S_HUNT, S_LEN, S_START, S_DATA, S_CHK, S_POST, S_DONE, S_ERR
    } state_t;
endpackage

// File: rtl/cfgld_frchk.sv
module cfgld_frchk #(
    parameter int CHK_W = 4,
    parameter logic [CHK_W-1:0] PATTERN = 4'b0101
) (
    input  logic [CHK_W-2:0] hist_i,
    input  logic             bit_i,
    output logic             ok_o
);
    logic [CHK_W-1:0] word;
    logic [CHK_W-1:0] eq;

    assign word = {hist_i, bit_i};

    for (genvar g = 0; g < CHK_W; g++) begin : g_bit
        assign eq[g] = (word[g] == PATTERN[g]);
    end

    assign ok_o = &eq;
endmodule

// File: rtl/cfgld_chain.sv
module cfgld_chain (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic express,
    input  logic pass_en,
    input  logic done_d,
    output logic dout_o
);
    logic dout_d, dout_q;

    always_comb begin
        if (express)      dout_d = done_d;
        else if (pass_en) dout_d = din;
        else              dout_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_q <= 1'b0;
        else        dout_q <= dout_d;
    end

    assign dout_o = dout_q;
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int NUM_FRAMES = 3,
    parameter int FAST_POS   = 2,
    parameter logic [CHK_W-1:0] CHK_PATTERN = 4'b0101,
    localparam int AW  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int BW  = (FRAME_BITS > LEN_W) ? FRAME_BITS : LEN_W,
    localparam int BCW = $clog2(BW) + 1,
    localparam int CW  = LEN_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  din,
    input  logic                  express,
    output logic                  pass_o,
    output logic                  done_d_o,
    output logic                  init_low_o,
    output logic                  done_o,
    output logic                  fast_o,
    output logic                  we_o,
    output logic [AW-1:0]         addr_o,
    output logic [FRAME_BITS-1:0] data_o
);
    typedef struct packed {
        state_t                st;
        logic [PRE_W-2:0]      hunt;
        logic [LEN_W-1:0]      len;
        logic [BCW-1:0]        bcnt;
        logic [CW-1:0]         cnt;
        logic [2:0]            pcnt;
        logic [AW-1:0]         fidx;
        logic [FRAME_BITS-1:0] data;
        logic [CHK_W-2:0]      chk;
        logic                  fast;
        logic                  err;
        logic                  done;
        logic                  we;
        logic [AW-1:0]         waddr;
        logic [FRAME_BITS-1:0] wdata;
    } seq_t;

    seq_t q, n;
    logic chk_ok;

    cfgld_frchk #(.CHK_W(CHK_W), .PATTERN(CHK_PATTERN)) u_chk (
        .hist_i (q.chk),
        .bit_i  (din),
        .ok_o   (chk_ok)
    );

    always_comb begin
        n    = q;
        n.we = 1'b0;
        if (q.st inside {S_LEN, S_START, S_DATA, S_CHK, S_POST} && (q.cnt != '1))
            n.cnt = q.cnt + 1'b1;
        case (q.st)
            S_HUNT: begin
                n.hunt = {q.hunt[PRE_W-3:0], din};
                if ({q.hunt, din} == PRE_CODE) begin
                    n.st   = S_LEN;
                    n.cnt  = CW'(PRE_W);
                    n.bcnt = '0;
                end
            end
            S_LEN: begin
                n.len = LEN_W'({q.len, din});
                if (q.bcnt == BCW'(LEN_W - 1)) begin
                    n.st   = S_START;
                    n.bcnt = '0;
                end else begin
                    n.bcnt = q.bcnt + 1'b1;
                end
            end
            S_START: begin
                if (din) begin
                    n.st  = S_ERR;
                    n.err = 1'b1;
                end else begin
                    n.st   = S_DATA;
                    n.bcnt = '0;
                end
            end
            S_DATA: begin
                n.data = FRAME_BITS'({q.data, din});
                if (q.fidx == '0 && q.bcnt == BCW'(FAST_POS) && din)
                    n.fast = 1'b1;
                if (q.bcnt == BCW'(FRAME_BITS - 1)) begin
                    n.st   = S_CHK;
                    n.bcnt = '0;
                end else begin
                    n.bcnt = q.bcnt + 1'b1;
                end
            end
            S_CHK: begin
                n.chk = (CHK_W-1)'({q.chk, din});
                if (q.bcnt == BCW'(CHK_W - 1)) begin
                    n.bcnt = '0;
                    if (chk_ok) begin
                        n.we    = 1'b1;
                        n.waddr = q.fidx;
                        n.wdata = q.data;
                        if (q.fidx == AW'(NUM_FRAMES - 1)) begin
                            n.st   = S_POST;
                            n.pcnt = '0;
                        end else begin
                            n.st   = S_START;
                            n.fidx = q.fidx + 1'b1;
                        end
                    end else begin
                        n.st  = S_ERR;
                        n.err = 1'b1;
                    end
                end else begin
                    n.bcnt = q.bcnt + 1'b1;
                end
            end
            S_POST: begin
                if (q.pcnt != 3'(TAIL)) n.pcnt = q.pcnt + 1'b1;
            end
            default: ;
        endcase
        if (n.st == S_POST) begin
            if (express ? (n.pcnt == 3'(TAIL))
                        : (n.cnt >= ({1'b0, n.len} + CW'(TAIL)))) begin
                n.st   = S_DONE;
                n.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_HUNT;
            q.hunt <= '1;
        end else begin
            q <= n;
        end
    end

    assign pass_o     = q.st inside {S_HUNT, S_LEN, S_POST, S_DONE};
    assign done_d_o   = n.done;
    assign init_low_o = q.err;
    assign done_o     = q.done;
    assign fast_o     = q.fast;
    assign we_o       = q.we;
    assign addr_o     = q.waddr;
    assign data_o     = q.wdata;

    // R5: the error request is sticky until reset
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_low_o) |-> init_low_o);
    // R5: no frame write once an error is flagged
    a_r5_no_write_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        init_low_o |-> !we_o);
    // R4: a write strobe lasts one clock
    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o);
    // R7: done is sticky and never coexists with an error
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_o) |-> done_o);
    a_r7_done_not_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && init_low_o));
    // R9: fast select is sticky
    a_r9_fast_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fast_o) |-> fast_o);
endmodule

// File: rtl/cfgld_top.sv
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int NUM_FRAMES = 3,
    parameter int FAST_POS   = 2,
    parameter logic [CHK_W-1:0] CHK_PATTERN = 4'b0101,
    localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_din,
    input  logic                  express_en,
    output logic                  chain_out,
    output logic                  init_low_o,
    output logic                  cfg_done,
    output logic                  fast_clk_sel,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [FRAME_BITS-1:0] mem_data
);
    logic pass_en, done_d;

    cfgld_seq #(
        .FRAME_BITS (FRAME_BITS),
        .NUM_FRAMES (NUM_FRAMES),
        .FAST_POS   (FAST_POS),
        .CHK_PATTERN(CHK_PATTERN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (cfg_din),
        .express    (express_en),
        .pass_o     (pass_en),
        .done_d_o   (done_d),
        .init_low_o (init_low_o),
        .done_o     (cfg_done),
        .fast_o     (fast_clk_sel),
        .we_o       (mem_we),
        .addr_o     (mem_addr),
        .data_o     (mem_data)
    );

    cfgld_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (cfg_din),
        .express (express_en),
        .pass_en (pass_en),
        .done_d  (done_d),
        .dout_o  (chain_out)
    );

    // R8: in express mode the chain output is the completion enable
    a_r8_express_enable: assert property (@(posedge clk) disable iff (!rst_n)
        express_en |-> (chain_out == cfg_done));
    // R3: normal mode keeps the chain high while a frame is being written
    a_r3_high_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !express_en) |-> chain_out);
endmodule

// File: tb/sim_cfgld_top.sv
`timescale 1ns/1ps
module sim_cfgld_top;
    localparam int FB = 8;
    localparam int NF = 3;
    localparam int HDR = 28;
    localparam int FRL = 1 + FB + 4;
    localparam int LAST = HDR + NF*FRL - 1;   // index of last frame bit (66)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b1;
    logic express = 1'b0;
    logic chain_out, init_low, done, fast, we;
    logic [1:0] addr;
    logic [FB-1:0] wdata;

    int errs = 0;
    int checks = 0;

    always #10 clk = ~clk;

    cfgld_top #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .FAST_POS(2), .CHK_PATTERN(4'b0101)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_din(din), .express_en(express),
        .chain_out(chain_out), .init_low_o(init_low), .cfg_done(done),
        .fast_clk_sel(fast), .mem_we(we), .mem_addr(addr), .mem_data(wdata)
    );

    // {express, d0, d1, d2, bad frame (3 = none), length}
    localparam logic [50:0] VEC [7] = '{
        {1'b0, 8'hA5, 8'h3C, 8'hF0, 2'd3, 24'd67},
        {1'b0, 8'h12, 8'h34, 8'h56, 2'd1, 24'd67},
        {1'b1, 8'hFF, 8'h00, 8'h81, 2'd3, 24'd0},
        {1'b0, 8'h00, 8'hFF, 8'h5A, 2'd3, 24'd70},
        {1'b0, 8'hC3, 8'h00, 8'h7E, 2'd3, 24'd40},
        {1'b1, 8'h24, 8'h42, 8'h99, 2'd0, 24'd67},
        {1'b0, 8'h81, 8'h18, 8'h66, 2'd2, 24'd67}
    };

    logic [FB-1:0] s_d [3];
    int  s_bad;
    bit  s_bstart;
    logic [23:0] s_len;
    int  exp_done_idx;
    int  nwr, wr_bad, dout_bad, done_idx;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic sbit(input int i);
        int f, o;
        if (i < 0)   return 1'b1;
        if (i < 4)   return 4'b0010 >> (3 - i);
        if (i < HDR) return s_len[23 - (i - 4)];
        if (i <= LAST) begin
            f = (i - HDR) / FRL;
            o = (i - HDR) % FRL;
            if (o == 0)  return (s_bstart && f == s_bad);
            if (o <= FB) return s_d[f][FB - o];
            return ((4'b0101 >> (3 - (o - FB - 1))) & 1) ^
                   (!s_bstart && f == s_bad && o == FB + 1);
        end
        return i[0];
    endfunction

    task automatic send(input int i);
        logic b, exp_dout;
        b = sbit(i);
        din = b;
        @(posedge clk);
        #2;
        if (express) exp_dout = (exp_done_idx >= 0 && i >= exp_done_idx);
        else if (i < HDR) exp_dout = b;
        else exp_dout = (s_bad != 3 || i <= LAST) ? 1'b1 : b;
        if (chain_out !== exp_dout) dout_bad++;
        if (we === 1'b1) begin
            if (nwr > 2 || addr !== 2'(nwr) || wdata !== s_d[nwr]) wr_bad++;
            nwr++;
        end
        if (done === 1'b1 && done_idx < 0) done_idx = i;
    endtask

    task automatic run(input logic ex, input logic [7:0] d0, input logic [7:0] d1,
                       input logic [7:0] d2, input int bad, input bit bstart,
                       input logic [23:0] len);
        int m;
        rst_n = 1'b0; din = 1'b1; express = ex;
        s_d[0] = d0; s_d[1] = d1; s_d[2] = d2;
        s_bad = bad; s_bstart = bstart; s_len = len;
        if (bad != 3) exp_done_idx = -1;
        else if (ex)  exp_done_idx = LAST + 4;
        else begin
            m = int'(len) + 3;
            exp_done_idx = (m > LAST) ? m : LAST;
        end
        nwr = 0; wr_bad = 0; dout_bad = 0; done_idx = -1;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        for (int i = -3; i <= LAST + 12; i++) send(i);
        if (ex) check(dout_bad == 0, "R8", "chain enable mismatches", dout_bad, 0);
        else    check(dout_bad == 0, "R2 R3 R6", "chain pass/hold mismatches", dout_bad, 0);
        check(wr_bad == 0 && nwr == ((bad == 3) ? 3 : bad), "R4", "good frame writes",
              nwr, (bad == 3) ? 3 : bad);
        check(init_low == (bad != 3), "R5", "init low request", init_low, bad != 3);
        check(done_idx == exp_done_idx, ex ? "R8" : "R7", "done clock index",
              done_idx, exp_done_idx);
        check(fast == d0[FB-1-2], "R9", "fast clock select", fast, d0[FB-1-2]);
    endtask

    initial begin
        #(20 * 200000);
        errs++; checks++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: outputs inactive in reset
        repeat (3) @(posedge clk);
        #2;
        check({chain_out, init_low, done, fast, we} == 5'b0, "R1", "reset outputs",
              {chain_out, init_low, done, fast, we}, 0);
        // table of scenarios
        for (int r = 0; r < 7; r++)
            run(VEC[r][50], VEC[r][49:42], VEC[r][41:34], VEC[r][33:26],
                int'(VEC[r][25:24]), 1'b0, VEC[r][23:0]);
        // R5: start bit of 1 in frame 1 is an error
        run(1'b0, 8'h5A, 8'hA5, 8'h0F, 1, 1'b1, 24'd67);
        // R1: reset clears the held error
        rst_n = 1'b0;
        @(posedge clk); #2;
        check(init_low == 1'b0 && done == 1'b0, "R1", "error cleared by reset",
              init_low, 0);
        rst_n = 1'b1;
        // R9: fast bit 0 in frame 0 leaves the slow rate (extra check)
        run(1'b0, 8'hDB, 8'h11, 8'h22, 3, 1'b0, 24'd67);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule